// File: doc/BRIEF.md
# Status Register and Write-Protection Unit

This unit keeps the protection state of a small serial EEPROM: a write-enable latch, a two-bit array protection level and a lock-enable bit that arms the hardware write-protect pin. It decodes that state into two answers for the rest of the device. One says whether a status-register write would be accepted. The other says whether a supplied array address may be programmed. It also forms the byte returned when the status register is read.

Commands reach it already decoded from the serial front end, one pulse per command while chip select is low. A status write is only armed during the frame. It is committed when chip select rises, and it then runs a timed internal cycle. A committed array write requested by the data path starts the same kind of timed cycle. While a cycle runs, the status byte reads as all ones, commands are ignored, and the write-enable latch drops when the cycle ends. The protection level and the lock-enable bit model nonvolatile cells, so their reset values are parameters.

Top module: `sr_wprot_top`

## Requirements
- R1: After synchronous reset the write-enable latch is 0, the protection level equals `BP_INIT`, the lock-enable bit equals `WPEN_INIT`, `busy` is 0, and with the default parameters `status_q` reads 0x00.
- R2: Op 2'b01 sets the write-enable latch and op 2'b10 clears it. This holds whatever the level of `wp_n`, provided no cycle is running.
- R3: When idle, `status_q` is {lock-enable, 3'b000, level[1:0], write-enable, busy=0}, bits 7 down to 0. Bits 6:4 of written data are dropped.
- R4: `busy` is high for exactly `CYCLE_LEN` clocks after a cycle starts. During that time `status_q` reads 0xFF.
- R5: With the write-enable latch set, `addr_wr_ok` reflects the protection level. Level 00 protects nothing, 01 protects the top quarter, 10 protects the top half and 11 protects everything.
- R6: `addr_wr_ok` is 0 whenever the write-enable latch is 0.
- R7: A status write (op 2'b11, new byte on `cmd_data`) issued without the write-enable latch set starts no cycle and changes nothing.
- R8: The hardware lock is on when `wp_n` is 0 and the lock-enable bit is 1. While it is on, `stwr_ok` is 0, and a status write is refused even when it would clear the lock-enable bit.
- R9: A lock that comes on while chip select is still low cancels the armed status write. A lock that comes on after the cycle has started does not stop that cycle.
- R10: While `busy` is high, latch commands, status writes and `arr_go` are ignored.
- R11: The write-enable latch is 0 at the end of every timed cycle, whether it was a status cycle or an array cycle.
- R12: An accepted status write starts its cycle on the clock after chip select rises. The new level and lock-enable bit become visible once the cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, low during a frame |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| cmd_valid | input | 1 | One-cycle pulse carrying a decoded command |
| cmd_op | input | 2 | 01 set latch, 10 clear latch, 11 status write |
| cmd_data | input | 8 | New status byte for a status write |
| arr_go | input | 1 | Committed array write requests a timed cycle |
| chk_addr | input | ADDR_W | Array address to be judged |
| status_q | output | 8 | Status read byte, registered |
| busy | output | 1 | Timed cycle in progress |
| stwr_ok | output | 1 | A status write would be accepted now |
| addr_wr_ok | output | 1 | `chk_addr` may be programmed now |

## Verification
The bench goes after the quarter and half boundaries, probing the address on each side of them. A decoder off by one address bit would protect the wrong half or leave the top quarter writable. It pulls `wp_n` low in two places: inside an armed frame, and just after commit. A design that samples the pin at the wrong moment either commits a write that should have been dropped or aborts a cycle already under way. It issues a latch command and a second `arr_go` during a busy cycle, then reads the latch back through `addr_wr_ok` and times the end of `busy`. A design that does not gate on `busy` would show a set latch or a stretched cycle. It also writes a byte with the reserved bits set and checks that the idle status byte still reads them as zero.

// File: rtl/srwp_pkg.sv
package srwp_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_SETWEN = 2'b01,
    OP_CLRWEN = 2'b10,
    OP_WRSTAT = 2'b11
  } srwp_op_e;

  localparam int SR_LOCK_BIT = 7;
  localparam int SR_LVL_HI   = 3;
  localparam int SR_LVL_LO   = 2;
  localparam int SR_WEN_BIT  = 1;

  function automatic logic [7:0] pack_status(input logic lock_en, input logic [1:0] lvl,
                                             input logic wen_b);
    logic [7:0] s;
    s = '0;
    s[SR_LOCK_BIT]           = lock_en;
    s[SR_LVL_HI:SR_LVL_LO]   = lvl;
    s[SR_WEN_BIT]            = wen_b;
    return s;
  endfunction
endpackage

// File: rtl/srwp_region_decode.sv
module srwp_region_decode #(
  parameter int ADDR_W = 10
) (
  input  logic [1:0]        lvl,
  input  logic [ADDR_W-1:0] addr,
  output logic              prot
);
  localparam int TOP = ADDR_W - 1;
  localparam int NXT = ADDR_W - 2;

  logic top_half;
  logic top_quarter;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign top_half    = addr[TOP];
      assign top_quarter = addr[TOP] & addr[NXT];
    end else begin : g_narrow
      assign top_half    = addr[0];
      assign top_quarter = addr[0];
    end
  endgenerate

  always_comb begin
    unique case (lvl)
      2'b00:   prot = 1'b0;
      2'b01:   prot = top_quarter;
      2'b10:   prot = top_half;
      default: prot = 1'b1;
    endcase
  end
endmodule

// File: rtl/srwp_cycle_timer.sv
module srwp_cycle_timer #(
  parameter int CYCLE_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLE_LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLE_LEN - 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/sr_wprot_top.sv
module sr_wprot_top #(
  parameter int         ADDR_W    = 10,
  parameter int         CYCLE_LEN = 16,
  parameter logic [1:0] BP_INIT   = 2'b00,
  parameter logic       WPEN_INIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wp_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [7:0]        cmd_data,
  input  logic              arr_go,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic [7:0]        status_q,
  output logic              busy,
  output logic              stwr_ok,
  output logic              addr_wr_ok
);
  import srwp_pkg::*;

  logic       wen;
  logic [1:0] lvl_r;
  logic       wpen_r;
  logic       pend;
  logic [2:0] pend_val;
  logic       cyc_stat;
  logic       cs_q;

  logic lock, cs_rise, cmd_take, stat_go, arr_take, cyc_start, cyc_done, prot;
  logic unused_bits;

  assign unused_bits = ^{cmd_data[6:4], cmd_data[1:0]};

  assign lock      = wpen_r & ~wp_n;
  assign cs_rise   = ~cs_q & cs_n;
  assign cmd_take  = cmd_valid & ~cs_n & ~busy;
  assign stat_go   = cs_rise & pend & ~lock & ~busy;
  assign arr_take  = arr_go & ~busy & ~stat_go;
  assign cyc_start = stat_go | arr_take;

  srwp_cycle_timer #(.CYCLE_LEN(CYCLE_LEN)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (cyc_start),
    .busy  (busy),
    .done  (cyc_done)
  );

  srwp_region_decode #(.ADDR_W(ADDR_W)) u_region (
    .lvl  (lvl_r),
    .addr (chk_addr),
    .prot (prot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wen      <= 1'b0;
      lvl_r    <= BP_INIT;
      wpen_r   <= WPEN_INIT;
      pend     <= 1'b0;
      pend_val <= '0;
      cyc_stat <= 1'b0;
      cs_q     <= 1'b1;
    end else begin
      cs_q <= cs_n;
      if (cmd_take) begin
        unique case (cmd_op)
          OP_SETWEN: wen <= 1'b1;
          OP_CLRWEN: wen <= 1'b0;
          OP_WRSTAT: if (wen && !lock) begin
            pend     <= 1'b1;
            pend_val <= {cmd_data[SR_LOCK_BIT], cmd_data[SR_LVL_HI:SR_LVL_LO]};
          end
          default: ;
        endcase
      end
      // lock arriving mid-frame drops the armed write
      if (pend && lock && !cs_n) pend <= 1'b0;
      if (cs_rise) pend <= 1'b0;
      if (cyc_start) cyc_stat <= stat_go;
      if (cyc_done) begin
        wen <= 1'b0;
        if (cyc_stat) begin
          wpen_r <= pend_val[2];
          lvl_r  <= pend_val[1:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q   <= pack_status(WPEN_INIT, BP_INIT, 1'b0);
      stwr_ok    <= 1'b0;
      addr_wr_ok <= 1'b0;
    end else begin
      status_q   <= busy ? 8'hFF : pack_status(wpen_r, lvl_r, wen);
      stwr_ok    <= wen & ~lock;
      addr_wr_ok <= wen & ~prot;
    end
  end
endmodule

// File: rtl/srwp_checker.sv
module srwp_checker (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       wen,
  input logic       wpen,
  input logic       wp_n,
  input logic       stwr_ok,
  input logic       addr_wr_ok,
  input logic [7:0] status_q
);
  // R4
  busy_ones_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (status_q == 8'hFF));

  // R3
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (status_q != 8'hFF) |-> (status_q[6:4] == 3'b000));

  // R6
  addr_needs_wen_chk: assert property (@(posedge clk) disable iff (rst)
    addr_wr_ok |-> $past(wen));

  // R8
  lock_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    stwr_ok |-> $past(wp_n || !wpen));

  // R11
  wen_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wen);

  // R10
  no_set_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !$rose(wen));
endmodule

bind sr_wprot_top srwp_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .wen        (wen),
  .wpen       (wpen_r),
  .wp_n       (wp_n),
  .stwr_ok    (stwr_ok),
  .addr_wr_ok (addr_wr_ok),
  .status_q   (status_q)
);

// File: tb/tb_sr_wprot_top.sv
module tb_sr_wprot_top;
  localparam int AW  = 10;
  localparam int LEN = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, wp_n = 1'b1, cmd_valid = 1'b0, arr_go = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_data = 8'h00;
  logic [AW-1:0] chk_addr = '0;
  logic [7:0] status_q;
  logic busy, stwr_ok, addr_wr_ok;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  typedef struct { int kind; logic [7:0] val; string tag; } item_t;
  item_t exp_q[$];

  always #10 clk = ~clk;

  sr_wprot_top #(.ADDR_W(AW), .CYCLE_LEN(LEN)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .arr_go(arr_go), .chk_addr(chk_addr),
    .status_q(status_q), .busy(busy), .stwr_ok(stwr_ok), .addr_wr_ok(addr_wr_ok)
  );

  // kind: 0 status byte, 1 busy, 2 address ok, 3 status write ok
  task automatic push(input int kind, input logic [7:0] val, input string tag);
    item_t it;
    it.kind = kind; it.val = val; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // monitor: compares queued items shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk); #3;
      while (exp_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = exp_q.pop_front();
        case (it.kind)
          0: act = status_q;
          1: act = {7'd0, busy};
          2: act = {7'd0, addr_wr_ok};
          default: act = {7'd0, stwr_ok};
        endcase
        n_cmp++;
        if (act !== it.val) begin
          n_bad++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.val);
        end
      end
    end
  end

  task automatic op_frame(input logic [1:0] op);
    @(negedge clk); cs_n = 1'b0; cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk); cmd_valid = 1'b0; cs_n = 1'b1;
    @(negedge clk);
  endtask

  // returns at the negedge where chip select rises
  task automatic stat_frame(input logic [7:0] d, input bit drop_wp);
    @(negedge clk); cs_n = 1'b0; cmd_valid = 1'b1; cmd_op = 2'b11; cmd_data = d;
    @(negedge clk); cmd_valid = 1'b0;
    if (drop_wp) begin wp_n = 1'b0; @(negedge clk); end
    cs_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_addr_ok(input logic [AW-1:0] a, input logic e, input string tag);
    @(negedge clk); chk_addr = a; push(2, {7'd0, e}, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);
    push(0, 8'h00, "R1 reset status"); push(1, 8'h00, "R1 reset busy");
    push(3, 8'h00, "R1 reset stwr_ok");
    chk_addr_ok(10'h000, 1'b0, "R6 no wen addr 000");

    op_frame(2'b01);
    push(0, 8'h02, "R2 set latch");
    chk_addr_ok(10'h3FF, 1'b1, "R5 level 00 top addr");
    wp_n = 1'b0;
    op_frame(2'b10);
    push(0, 8'h00, "R2 clear latch with pin low");
    wp_n = 1'b1;

    stat_frame(8'h84, 1'b0); idle(LEN + 3);
    push(0, 8'h00, "R7 no wen status write"); push(1, 8'h00, "R7 no cycle");

    op_frame(2'b01);
    stat_frame(8'hF4, 1'b0);
    push(1, 8'h01, "R12 cycle starts after cs rise");
    idle(LEN - 1); push(1, 8'h01, "R4 busy last cycle");
    push(0, 8'hFF, "R4 reads ones while busy");
    idle(1); push(1, 8'h00, "R4 busy ends");
    idle(2); push(0, 8'h84, "R3 R11 R12 new status, pad dropped");

    op_frame(2'b01);
    push(0, 8'h86, "R2 latch set again");
    chk_addr_ok(10'h2FF, 1'b1, "R5 quarter below");
    chk_addr_ok(10'h300, 1'b0, "R5 quarter boundary");

    @(negedge clk); wp_n = 1'b0; idle(1);
    push(3, 8'h00, "R8 lock drops stwr_ok");
    stat_frame(8'h00, 1'b0); idle(3);
    push(1, 8'h00, "R8 refused no cycle"); idle(LEN);
    push(0, 8'h86, "R8 clear of lock bit refused");

    wp_n = 1'b1; idle(1);
    push(3, 8'h01, "R8 pin high allows status write");
    stat_frame(8'h08, 1'b1);
    push(1, 8'h00, "R9 dropped mid frame"); idle(LEN);
    wp_n = 1'b1;
    push(0, 8'h86, "R9 status unchanged after drop");

    stat_frame(8'h08, 1'b0);
    @(negedge clk); wp_n = 1'b0;
    idle(LEN + 3);
    push(0, 8'h08, "R9 R12 cycle survives late pin fall");
    wp_n = 1'b1;

    op_frame(2'b01);
    chk_addr_ok(10'h1FF, 1'b1, "R5 half below");
    chk_addr_ok(10'h200, 1'b0, "R5 half boundary");

    @(negedge clk); arr_go = 1'b1;
    @(negedge clk); arr_go = 1'b0;
    idle(LEN + 2);
    push(0, 8'h08, "R11 latch cleared after array cycle");

    // R10: second start and latch set while busy are both ignored
    @(negedge clk); arr_go = 1'b1; push(1, 8'h01, "R10 busy begins");
    @(negedge clk); arr_go = 1'b0;
    idle(2);
    @(negedge clk); arr_go = 1'b1; cs_n = 1'b0; cmd_valid = 1'b1; cmd_op = 2'b01;
    @(negedge clk); arr_go = 1'b0; cs_n = 1'b1; cmd_valid = 1'b0; chk_addr = 10'h000;
    push(2, 8'h00, "R10 latch set ignored while busy");
    idle(LEN - 6); push(1, 8'h01, "R10 busy last cycle");
    idle(1); push(1, 8'h00, "R10 busy not stretched");

    idle(3);
    op_frame(2'b01);
    stat_frame(8'h0C, 1'b0); idle(LEN + 3);
    push(0, 8'h0C, "R12 level 11 applied");
    op_frame(2'b01);
    chk_addr_ok(10'h000, 1'b0, "R5 level 11 bottom");
    push(0, 8'h0E, "R2 latch with level 11");

    idle(3);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule